// File: doc/BRIEF.md
# Lock-aware victim way selector

This block chooses which way of one eight-way set receives a new line when a miss is allocated. It honours two lock modes. In the first, the whole cache is frozen and no allocation is allowed. In the second, a contiguous group of ways starting at way 0 is locked. Under way locking, an empty entry inside a locked way can still take a fill. Once that entry is filled it is valid, and because it lies in a locked way it is never chosen for replacement afterwards. The block holds a small lock configuration register and the set's seven-bit tree pseudo-LRU state. Each hit or fill access updates the replacement state.

A miss request samples the set's valid bits together with the current configuration and replacement state. The next cycle presents the victim way, a flag saying whether allocation is permitted, and a strobe that marks the result as fresh. If any way is invalid, the lowest-numbered invalid way wins. This puts the first fill after an invalidate of the whole cache into way 0. When every way is valid, the pseudo-LRU tree picks the victim. If that pick falls inside the locked range, it is redirected to the first unlocked way.

Top module: `way_victim_sel`

## Requirements
- R1: A synchronous active-high reset clears the lock count to 0, the whole-lock flag, the error flag, the replacement state, the victim (0), the allocate flag and the result strobe.
- R2: A configuration write (cfg_wr high for one cycle) stores cfg_whole and, when cfg_count is 0..7, stores that count, meaning ways 0..count-1 are locked. The stored values appear on the outputs in the following cycle.
- R3: A write whose cfg_count is 8..15 stores a count of 7 and sets the error flag. The error flag stays set until reset, including across later legal writes.
- R4: While the whole-lock flag is set, a miss gives alloc_ok = 0 whatever the valid bits are, including when every entry is invalid.
- R5: While the whole-lock flag is clear and at least one valid bit is 0, the victim is the lowest-numbered invalid way, even when that way lies inside the locked range.
- R6: While the whole-lock flag is clear and all ways are valid, the victim is the tree pick, subject to R7. The tree bits are heap ordered: bit 0 is the root, and the children of bit k are bits 2k+1 (for value 0) and 2k+2 (for value 1). The path of three bit values, read from the root, gives the way number MSB first.
- R7: When all ways are valid and the tree pick is below the lock count N, the victim is way N.
- R8: An access (acc_vld with acc_way) sets every tree bit on the path to that way to the complement of the path direction toward it. The new state is visible on plru_o one cycle later, and accesses to locked ways update the state as well.
- R9: Victim, alloc_ok and res_vld are registered. They reflect a miss request one cycle after the request. res_vld is high only in that cycle. A miss uses the configuration and replacement state held before any write or access in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Lock configuration write strobe |
| cfg_whole | input | 1 | Whole-cache lock value to write |
| cfg_count | input | 4 | Requested locked-way count |
| acc_vld | input | 1 | Hit or fill access to the set |
| acc_way | input | 3 | Way accessed |
| miss_req | input | 1 | Miss allocation request |
| valid_i | input | 8 | Per-way valid bits of the set |
| victim_o | output | 3 | Selected victim way |
| alloc_ok_o | output | 1 | Allocation permitted |
| res_vld_o | output | 1 | Victim result is fresh |
| plru_o | output | 7 | Current replacement tree state |
| lock_count_o | output | 3 | Stored locked-way count |
| whole_lock_o | output | 1 | Stored whole-lock flag |
| cfg_err_o | output | 1 | Sticky illegal-count flag |

## Verification
The hardest case to reach is a set that is fully valid while the replacement tree points into the locked range. The tree can only be steered through accesses. The stimulus therefore runs a long sequence of accesses over the ways. After each access it tracks the expected tree in the bench and issues a fully valid miss for every lock count from 0 to 7. This gives every tree pick both below and above each count. A separate sweep crosses all 256 valid patterns with every count and both whole-lock settings, which covers empty locked ways and the invalid-first rule.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
    localparam int WAYS     = 8;
    localparam int IDX_W    = $clog2(WAYS);
    localparam int TREE_W   = WAYS - 1;
    localparam int CNT_W    = IDX_W + 1;
    localparam int MAX_LOCK = WAYS - 1;

    typedef logic [IDX_W-1:0]  way_t;
    typedef logic [TREE_W-1:0] tree_t;

    // Follow the tree from the root; each bit value chooses the child.
    function automatic way_t tree_pick(input tree_t t);
        way_t w;
        int   node;
        w    = '0;
        node = 0;
        for (int lvl = 0; lvl < IDX_W; lvl++) begin
            w    = {w[IDX_W-2:0], t[node]};
            node = 2 * node + 1 + int'(t[node]);
        end
        return w;
    endfunction

    // Point every node on the way's path away from it.
    function automatic tree_t tree_touch(input tree_t t, input way_t w);
        tree_t n;
        int    node;
        logic  dir;
        n    = t;
        node = 0;
        for (int lvl = 0; lvl < IDX_W; lvl++) begin
            dir     = w[IDX_W-1-lvl];
            n[node] = ~dir;
            node    = 2 * node + 1 + int'(dir);
        end
        return n;
    endfunction
endpackage

// File: rtl/vsel_lock_cfg.sv
module vsel_lock_cfg
    import vsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             whole_in,
    input  logic [CNT_W-1:0] count_in,
    output logic             whole,
    output way_t             count,
    output logic             err
);
    typedef struct packed {
        logic whole;
        way_t count;
        logic err;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            cfg_d.whole = whole_in;
            if (count_in > CNT_W'(MAX_LOCK)) begin
                cfg_d.count = way_t'(MAX_LOCK);
                cfg_d.err   = 1'b1;
            end else begin
                cfg_d.count = count_in[IDX_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    assign whole = cfg_q.whole;
    assign count = cfg_q.count;
    assign err   = cfg_q.err;

    // R3
    saturate_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && count_in > CNT_W'(MAX_LOCK)) |=> (err && count == way_t'(MAX_LOCK)));

    // R3
    sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R2
    legal_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && count_in <= CNT_W'(MAX_LOCK)) |=> (count == $past(count_in[IDX_W-1:0])));
endmodule

// File: rtl/vsel_plru.sv
module vsel_plru
    import vsel_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  acc_vld,
    input  way_t  acc_way,
    output tree_t tree
);
    tree_t tree_d, tree_q;

    always_comb begin
        tree_d = tree_q;
        if (acc_vld) tree_d = tree_touch(tree_q, acc_way);
    end

    always_ff @(posedge clk) begin
        if (rst) tree_q <= '0;
        else     tree_q <= tree_d;
    end

    assign tree = tree_q;

    // R8
    away_from_access_chk: assert property (@(posedge clk) disable iff (rst)
        acc_vld |=> (tree_pick(tree_q) != $past(acc_way)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_vld |=> $stable(tree_q));
endmodule

// File: rtl/vsel_pick.sv
module vsel_pick
    import vsel_pkg::*;
(
    input  logic [WAYS-1:0] valid,
    input  tree_t           tree,
    input  logic            whole,
    input  way_t            count,
    output way_t            way,
    output logic            ok
);
    way_t first_inv;
    logic any_inv;
    way_t lru_way;

    always_comb begin
        first_inv = '0;
        any_inv   = 1'b0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                first_inv = way_t'(i);
                any_inv   = 1'b1;
            end
        end
    end

    always_comb begin
        lru_way = tree_pick(tree);
        if (lru_way < count) lru_way = count;
    end

    always_comb begin
        ok  = !whole;
        way = any_inv ? first_inv : lru_way;
    end
endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel
    import vsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic             cfg_whole,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             acc_vld,
    input  way_t             acc_way,
    input  logic             miss_req,
    input  logic [WAYS-1:0]  valid_i,
    output way_t             victim_o,
    output logic             alloc_ok_o,
    output logic             res_vld_o,
    output tree_t            plru_o,
    output way_t             lock_count_o,
    output logic             whole_lock_o,
    output logic             cfg_err_o
);
    typedef struct packed {
        logic vld;
        logic ok;
        way_t way;
    } res_t;

    res_t  res_d, res_q;
    logic  whole;
    way_t  count;
    tree_t tree;
    way_t  pick_way;
    logic  pick_ok;

    vsel_lock_cfg cfg_i (
        .clk(clk), .rst(rst), .wr(cfg_wr), .whole_in(cfg_whole),
        .count_in(cfg_count), .whole(whole), .count(count), .err(cfg_err_o)
    );

    vsel_plru plru_i (
        .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_way(acc_way), .tree(tree)
    );

    vsel_pick pick_i (
        .valid(valid_i), .tree(tree), .whole(whole), .count(count),
        .way(pick_way), .ok(pick_ok)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = miss_req;
        res_d.ok  = 1'b0;
        if (miss_req) begin
            res_d.ok  = pick_ok;
            res_d.way = pick_way;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign victim_o     = res_q.way;
    assign alloc_ok_o   = res_q.ok;
    assign res_vld_o    = res_q.vld;
    assign plru_o       = tree;
    assign lock_count_o = count;
    assign whole_lock_o = whole;

    // R4
    whole_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_req && whole) |=> !alloc_ok_o);

    // R5
    invalid_first_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_req && !whole && !(&valid_i)) |=>
            ((($past(valid_i) >> victim_o) & 8'd1) == 8'd0));

    // R7
    skip_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_req && !whole && (&valid_i)) |=> (victim_o >= $past(count)));

    // R9
    strobe_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_ok_o |-> res_vld_o);
endmodule

// File: tb/way_victim_sel_tb_top.sv
module way_victim_sel_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_wr, cfg_whole, acc_vld, miss_req;
    logic [3:0] cfg_count;
    logic [2:0] acc_way;
    logic [7:0] valid_i;
    logic [2:0] victim_o, lock_count_o;
    logic       alloc_ok_o, res_vld_o, whole_lock_o, cfg_err_o;
    logic [6:0] plru_o;

    int checks = 0;
    int failures = 0;
    logic [6:0] m_tree;

    always #2.5 clk = ~clk;

    way_victim_sel dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_whole(cfg_whole),
        .cfg_count(cfg_count), .acc_vld(acc_vld), .acc_way(acc_way),
        .miss_req(miss_req), .valid_i(valid_i), .victim_o(victim_o),
        .alloc_ok_o(alloc_ok_o), .res_vld_o(res_vld_o), .plru_o(plru_o),
        .lock_count_o(lock_count_o), .whole_lock_o(whole_lock_o),
        .cfg_err_o(cfg_err_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected tree pick from the R6 heap encoding.
    function automatic int m_pick(input logic [6:0] t);
        int b0, b1, b2;
        b0 = int'(t[0]);
        b1 = b0 ? int'(t[2]) : int'(t[1]);
        b2 = int'(t[3 + 2 * b0 + b1]);
        return 4 * b0 + 2 * b1 + b2;
    endfunction

    function automatic logic [6:0] m_touch(input logic [6:0] t, input int w);
        logic [6:0] n;
        int hi, mid;
        n    = t;
        hi   = w / 4;
        mid  = (w / 2) % 2;
        n[0] = (hi == 0);
        n[1 + hi] = (mid == 0);
        n[3 + 2 * hi + mid] = ((w % 2) == 0);
        return n;
    endfunction

    function automatic int m_victim(input logic [7:0] v, input logic [6:0] t, input int n);
        int p;
        for (int i = 0; i < 8; i++) if (!v[i]) return i;
        p = m_pick(t);
        return (p < n) ? n : p;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_tree = '0;
    endtask

    task automatic cfg_write(input logic whole, input int cnt);
        cfg_wr = 1'b1; cfg_whole = whole; cfg_count = 4'(cnt);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic access(input int w);
        acc_vld = 1'b1; acc_way = 3'(w);
        @(negedge clk);
        acc_vld = 1'b0;
        m_tree = m_touch(m_tree, w);
        chk("R8 tree", int'(plru_o), int'(m_tree));
    endtask

    task automatic miss(input logic [7:0] v, input logic whole, input int n, input string req);
        miss_req = 1'b1; valid_i = v;
        @(negedge clk);
        miss_req = 1'b0;
        chk("R9 strobe", int'(res_vld_o), 1);
        if (whole) begin
            chk("R4 alloc", int'(alloc_ok_o), 0);
        end else begin
            chk({req, " alloc"}, int'(alloc_ok_o), 1);
            chk({req, " victim"}, int'(victim_o), m_victim(v, m_tree, n));
        end
        @(negedge clk);
        chk("R9 strobe low", int'(res_vld_o), 0);
    endtask

    initial begin
        #900000;
        failures++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_wr = 0; cfg_whole = 0; cfg_count = 0;
        acc_vld = 0; acc_way = 0; miss_req = 0; valid_i = '1;
        m_tree = '0;
        do_reset();
        // R1
        chk("R1 victim", int'(victim_o), 0);
        chk("R1 alloc", int'(alloc_ok_o), 0);
        chk("R1 strobe", int'(res_vld_o), 0);
        chk("R1 tree", int'(plru_o), 0);
        chk("R1 count", int'(lock_count_o), 0);
        chk("R1 whole", int'(whole_lock_o), 0);
        chk("R1 err", int'(cfg_err_o), 0);

        // R2 legal counts, R3 saturation and stickiness
        for (int c = 0; c < 8; c++) begin
            cfg_write(c[0], c);
            chk("R2 count", int'(lock_count_o), c);
            chk("R2 whole", int'(whole_lock_o), c % 2);
            chk("R3 err clear", int'(cfg_err_o), 0);
        end
        for (int c = 8; c < 16; c++) begin
            cfg_write(1'b0, c);
            chk("R3 saturate", int'(lock_count_o), 7);
            chk("R3 err set", int'(cfg_err_o), 1);
        end
        cfg_write(1'b0, 2);
        chk("R2 count after error", int'(lock_count_o), 2);
        chk("R3 err sticky", int'(cfg_err_o), 1);
        do_reset();
        chk("R1 err cleared", int'(cfg_err_o), 0);
        chk("R1 count cleared", int'(lock_count_o), 0);

        // R4 R5 R7: all valid patterns, counts, lock modes with tree at zero
        for (int w = 0; w < 2; w++) begin
            for (int n = 0; n < 8; n++) begin
                cfg_write(w[0], n);
                for (int v = 0; v < 256; v++) begin
                    miss(8'(v), w[0], n, (v == 255) ? "R7" : "R5");
                end
            end
        end

        // R6 R7 R8: steer the tree and probe full sets at every count
        do_reset();
        for (int i = 0; i < 160; i++) begin
            access((i * 5 + i / 3) % 8);
            for (int n = 0; n < 8; n++) begin
                cfg_write(1'b0, n);
                miss(8'hff, 1'b0, n, (n == 0) ? "R6" : "R7");
            end
        end

        // R9: same-cycle access and miss uses the old tree
        do_reset();
        cfg_write(1'b0, 0);
        acc_vld = 1'b1; acc_way = 3'd0; miss_req = 1'b1; valid_i = 8'hff;
        @(negedge clk);
        acc_vld = 1'b0; miss_req = 1'b0;
        chk("R9 old tree victim", int'(victim_o), 0);
        m_tree = m_touch(m_tree, 0);
        chk("R8 tree after", int'(plru_o), int'(m_tree));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule